// File: doc/BRIEF.md
# Bit-Serial Instruction Timing Sequencer

This block generates the timing framework for a processor whose datapath handles one bit per bit slot. It divides the master clock into bit slots of four clocks and groups 14 slots into a phase. Three phases make a basic instruction cycle of 168 clocks. The block exposes a sub-cycle index inside each slot, a bit index inside each phase and a phase index inside each cycle. It also drives one-clock strobes at the start of every slot and every phase, and a pulse on the final clock of each instruction. A serial ALU and its shift registers use these outputs to decide what to do on each clock: read, compute, shift or write.

Long operations such as multiply or divide need more time, so an instruction can be stretched by whole basic cycles. On the clock where an unextended instruction would end, a request is sampled together with a count N. If N is non-zero, the end pulse is withheld and the instruction runs a further N × 168 clocks. The slot, bit and phase counters keep their normal rhythm through the extension, so the serial datapath sees the same pattern in every basic cycle.

Top module: `serial_phase_seq`

## Requirements
- R1: After a clock edge with `rst_n` low, `sub_idx`, `bit_idx` and `phase_idx` are 0, `ext_busy` is 0, and `instr_end` is 0 as long as no request is present.
- R2: `sub_idx` steps 0,1,2,3 and then returns to 0 on every clock. `bit_stb` is high exactly when `sub_idx` is 0.
- R3: `bit_idx` goes up by one after each clock with `sub_idx` = 3, and goes from 13 back to 0.
- R4: `phase_idx` goes up by one after each clock with `bit_idx` = 13 and `sub_idx` = 3, and goes from 2 back to 0. `phase_stb` is high exactly when `sub_idx` and `bit_idx` are both 0.
- R5: With no extension, `instr_end` is high for one clock in every 168, on the clock with phase 2, bit 13 and sub-cycle 3, and on no other clock.
- R6: If `mc_req` is 1 and `mc_cycles` = N > 0 on the final clock of an unextended instruction, `instr_end` stays low on that clock. It then pulses exactly N × 168 clocks later. `ext_busy` is high from the clock after the request through the clock of that pulse.
- R7: A request with `mc_cycles` = 0 has no effect: `instr_end` pulses as if no request were present.
- R8: `mc_req` is ignored on every clock other than the final clock of an unextended instruction, including the basic-cycle boundaries inside an extension.
- R9: Sub-cycle, bit and phase counting continue unchanged while `ext_busy` is high.
- R10: A reset during an extension clears the extension (`ext_busy` = 0) and restarts all counters at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_req | input | 1 | Extension request, sampled on the final clock of an unextended instruction |
| mc_cycles | input | 4 | Number N of extra basic cycles requested |
| sub_idx | output | 2 | Clock position inside the current bit slot |
| bit_stb | output | 1 | High on the first clock of every bit slot |
| bit_idx | output | 4 | Bit slot position inside the current phase |
| phase_stb | output | 1 | High on the first clock of every phase |
| phase_idx | output | 2 | Phase position inside the current basic cycle |
| instr_end | output | 1 | High on the last clock of an instruction |
| ext_busy | output | 1 | High while an instruction is being extended |

## Verification
The bench targets three groups of cases.

The first is the counter wrap points: sub-cycle 3 to 0, bit 13 to 0 and phase 2 to 0. A counter off by one at any of these moves every later strobe and shifts the end pulse away from the 168-clock grid.

The second is extension. The bench holds the request high through a full 15-cycle extension, and it also issues requests with a count of zero. A design that re-samples the request at inner boundaries would never end the instruction. A design that treats a zero count as a real request would drop an end pulse.

The third is reset in the middle of an extension. A design that keeps its remaining-cycle count across reset would report `ext_busy` and end its next instruction late.

// File: rtl/seq_pkg.sv
// Package: shared helpers for the bit-serial timing sequencer.
// Assumes: counter moduli are at least 1.
package seq_pkg;

    // Width of an index that counts 0..n-1, at least one bit
    function automatic int unsigned idx_w(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Conventional role of each clock in a four-clock bit slot
    typedef enum logic [1:0] {
        SLOT_READ    = 2'd0,
        SLOT_COMPUTE = 2'd1,
        SLOT_SHIFT   = 2'd2,
        SLOT_WRITE   = 2'd3
    } slot_role_e;

endpackage

// File: rtl/wrap_ctr.sv
// Module: wrap_ctr
// A modulo-MOD counter that advances when adv is high. It flags its
// terminal value so that the next level can chain on it.
// Assumes: MOD >= 2; reset is synchronous and active low.
module wrap_ctr
    import seq_pkg::*;
#(
    parameter int unsigned MOD = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      adv,
    output logic [idx_w(MOD)-1:0]     cnt,
    output logic                      at_last
);
    localparam int unsigned W = idx_w(MOD);
    localparam logic [W-1:0] LAST = W'(MOD - 1);

    // Purpose: count 0..MOD-1 and wrap on an advance at the terminal value
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (adv)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    // Purpose: terminal-value flag for the chained level
    always_comb at_last = (cnt == LAST);

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/ext_ctr.sv
// Module: ext_ctr
// Holds the number of extra basic cycles still owed by the current
// instruction. It decides whether a basic-cycle boundary ends the
// instruction.
// Assumes: cyc_end is high for one clock at the last clock of each
// basic cycle; the request counts only when no extension is running.
module ext_ctr #(
    parameter int unsigned EXT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_end,
    input  logic             mc_req,
    input  logic [EXT_W-1:0] mc_cycles,
    output logic             ext_busy,
    output logic             instr_end
);
    logic [EXT_W-1:0] remain;
    logic             take_req;

    // Purpose: a real request appears on the final clock of an unextended instruction
    always_comb take_req = cyc_end && (remain == '0) && mc_req && (mc_cycles != '0);

    // Purpose: load the extension on an accepted request, count it down per basic cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (take_req)
            remain <= mc_cycles;
        else if (cyc_end && remain != '0)
            remain <= remain - 1'b1;
    end

    // Purpose: end the instruction on a boundary that owes no further cycles
    always_comb begin
        ext_busy  = (remain != '0);
        instr_end = cyc_end && !take_req && (remain <= EXT_W'(1));
    end

    // R6
    ext_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && !ext_busy && mc_req && mc_cycles != '0) |=> ext_busy);

    // R6
    no_end_mid_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_busy && !cyc_end) |=> !($past(ext_busy) && !ext_busy && !$past(instr_end)));

endmodule

// File: rtl/serial_phase_seq.sv
// Module: serial_phase_seq
// Timing generator for a bit-serial processor. It chains three counters
// (clock inside a bit slot, bit inside a phase, phase inside a basic
// cycle) and an extension counter that stretches an instruction by
// whole basic cycles.
// Assumes: synchronous active-low reset; mc_req and mc_cycles are
// synchronous to clk.
module serial_phase_seq
    import seq_pkg::*;
#(
    parameter int unsigned CLKS_PER_BIT   = 4,
    parameter int unsigned BITS_PER_PHASE = 14,
    parameter int unsigned PHASES         = 3,
    parameter int unsigned EXT_W          = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              mc_req,
    input  logic [EXT_W-1:0]                  mc_cycles,
    output logic [idx_w(CLKS_PER_BIT)-1:0]    sub_idx,
    output logic                              bit_stb,
    output logic [idx_w(BITS_PER_PHASE)-1:0]  bit_idx,
    output logic                              phase_stb,
    output logic [idx_w(PHASES)-1:0]          phase_idx,
    output logic                              instr_end,
    output logic                              ext_busy
);
    localparam int unsigned SW = idx_w(CLKS_PER_BIT);
    localparam int unsigned BW = idx_w(BITS_PER_PHASE);
    localparam int unsigned PW = idx_w(PHASES);
    localparam logic [SW-1:0] SUB_LAST   = SW'(CLKS_PER_BIT - 1);
    localparam logic [BW-1:0] BIT_LAST   = BW'(BITS_PER_PHASE - 1);
    localparam logic [PW-1:0] PHASE_LAST = PW'(PHASES - 1);

    logic slot_last, bit_last, phase_last;
    logic bit_adv, phase_adv, cyc_end;
    logic run_q;

    // Purpose: sub-cycle counter, always advancing
    wrap_ctr #(.MOD(CLKS_PER_BIT)) u_slot (
        .clk(clk), .rst_n(rst_n), .adv(1'b1),
        .cnt(sub_idx), .at_last(slot_last)
    );

    // Purpose: advance conditions for the chained counters
    always_comb begin
        bit_adv   = slot_last;
        phase_adv = slot_last && bit_last;
        cyc_end   = phase_adv && phase_last;
    end

    // Purpose: bit counter, advancing once per slot
    wrap_ctr #(.MOD(BITS_PER_PHASE)) u_bit (
        .clk(clk), .rst_n(rst_n), .adv(bit_adv),
        .cnt(bit_idx), .at_last(bit_last)
    );

    // Purpose: phase counter, advancing once per phase
    wrap_ctr #(.MOD(PHASES)) u_phase (
        .clk(clk), .rst_n(rst_n), .adv(phase_adv),
        .cnt(phase_idx), .at_last(phase_last)
    );

    // Purpose: extension bookkeeping and end-of-instruction decision
    ext_ctr #(.EXT_W(EXT_W)) u_ext (
        .clk(clk), .rst_n(rst_n), .cyc_end(cyc_end),
        .mc_req(mc_req), .mc_cycles(mc_cycles),
        .ext_busy(ext_busy), .instr_end(instr_end)
    );

    // Purpose: start-of-slot and start-of-phase strobes
    always_comb begin
        bit_stb   = (sub_idx == '0);
        phase_stb = bit_stb && (bit_idx == '0);
    end

    // Purpose: marks clocks whose previous edge was outside reset
    always_ff @(posedge clk) run_q <= rst_n;

    // R2
    sub_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(sub_idx) != SUB_LAST) |-> sub_idx == $past(sub_idx) + 1'b1);

    // R3
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(sub_idx) != SUB_LAST) |-> bit_idx == $past(bit_idx));

    // R4
    phase_stb_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_stb |-> (sub_idx == '0 && bit_idx == '0 && bit_stb));

    // R5
    end_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_end |-> (sub_idx == SUB_LAST && bit_idx == BIT_LAST && phase_idx == PHASE_LAST));

endmodule

// File: tb/tb_serial_phase_seq.sv
module tb_serial_phase_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_req = 1'b0;
    logic [3:0] mc_cycles = '0;
    logic [1:0] sub_idx;
    logic       bit_stb;
    logic [3:0] bit_idx;
    logic       phase_stb;
    logic [1:0] phase_idx;
    logic       instr_end;
    logic       ext_busy;

    int vecs = 0;
    int errs = 0;
    int t = 0;
    int owe = 0;
    bit first_after_reset = 1'b1;
    bit boot = 1'b1;
    bit done = 1'b0;

    always #4 clk = ~clk;

    serial_phase_seq dut (
        .clk(clk), .rst_n(rst_n), .mc_req(mc_req), .mc_cycles(mc_cycles),
        .sub_idx(sub_idx), .bit_stb(bit_stb), .bit_idx(bit_idx),
        .phase_stb(phase_stb), .phase_idx(phase_idx),
        .instr_end(instr_end), .ext_busy(ext_busy)
    );

    function automatic bit is_cyc_end(input int tt);
        return (tt % 168) == 167;
    endfunction

    function automatic bit exp_end(input int tt, input int ow, input bit rq, input int n);
        if (!is_cyc_end(tt)) return 1'b0;
        if (ow == 0) return !(rq && n != 0);
        return ow == 1;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual %0d expected %0d at t=%0d", req, what, act, exp, t);
        end
    endtask

    // One clock: drive at falling edge, check, then advance the model at rising edge
    task automatic step(input bit rn, input bit rq, input int n);
        string ctag, etag;
        @(negedge clk);
        rst_n = rn; mc_req = rq; mc_cycles = 4'(n);
        #1;
        if (rn) begin
            if (first_after_reset) ctag = boot ? "R1" : "R10";
            else if (owe > 0) ctag = "R9";
            else ctag = "";
            chk(ctag == "" ? "R2" : ctag, "sub_idx", sub_idx, t % 4);
            chk(ctag == "" ? "R2" : ctag, "bit_stb", bit_stb, (t % 4) == 0);
            chk(ctag == "" ? "R3" : ctag, "bit_idx", bit_idx, (t / 4) % 14);
            chk(ctag == "" ? "R4" : ctag, "phase_idx", phase_idx, (t / 56) % 3);
            chk(ctag == "" ? "R4" : ctag, "phase_stb", phase_stb, (t % 56) == 0);
            if (first_after_reset) etag = boot ? "R1" : "R10";
            else if (owe > 0) etag = rq ? "R8" : "R6";
            else if (is_cyc_end(t) && rq) etag = (n == 0) ? "R7" : "R6";
            else if (rq) etag = "R8";
            else etag = "R5";
            chk(etag, "instr_end", instr_end, exp_end(t, owe, rq, n));
            chk(first_after_reset ? etag : "R6", "ext_busy", ext_busy, owe != 0);
        end
        @(posedge clk);
        if (!rn) begin
            t = 0; owe = 0; first_after_reset = 1'b1;
        end else begin
            if (is_cyc_end(t)) begin
                if (owe == 0) begin
                    if (rq) owe = n;
                end else owe--;
            end
            t++;
            first_after_reset = 1'b0;
        end
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5eed);
        step(1'b0, 1'b0, 0);
        step(1'b0, 1'b0, 0);
        // R5: two plain instructions
        for (int i = 0; i < 2 * 168; i++) step(1'b1, 1'b0, 0);
        boot = 1'b0;
        // R8: request held through a maximal extension and the next instruction
        for (int i = 0; i < 17 * 168 + 40; i++) step(1'b1, 1'b1, 15);
        // R7: zero-count requests held high
        for (int i = 0; i < 3 * 168; i++) step(1'b1, 1'b1, 0);
        // R10: reset in the middle of an extension
        while (!is_cyc_end(t)) step(1'b1, 1'b0, 0);
        step(1'b1, 1'b1, 3);
        for (int i = 0; i < 200; i++) step(1'b1, 1'b0, 0);
        step(1'b0, 1'b0, 0);
        for (int i = 0; i < 2 * 168; i++) step(1'b1, 1'b0, 0);
        // Random mix of requests and counts, with an occasional reset
        for (int i = 0; i < 40 * 168; i++) begin
            int unsigned r;
            r = $urandom;
            step((r % 3000) != 7, r[4], int'(r[9:8]));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule